// File: doc/BRIEF.md
# Decimal-Capable Accumulator Arithmetic Unit

This block is the arithmetic datapath of an accumulator-style processor core. It is purely combinational. It takes the accumulator value, a data operand, the incoming carry flag, a decimal-mode flag, a width-select flag and a two-bit operation code. In the same evaluation it returns the result, four condition flags (negative, overflow, zero, carry) and one write enable per flag. The write enables tell the register file which flags the operation changes.

There are four operations: add with carry, subtract with borrow, increment and decrement. Add and subtract pass on a carry, which on subtract means "no borrow was needed", so operands of several words can be chained. When decimal mode is set, add and subtract work on packed decimal digits with a correction in each digit. Increment and decrement always work in binary, ignore the carry and leave carry and overflow alone. A width-select input picks a byte-wide or a word-wide operation at run time. Instruction decoding, operand fetch and timing are done outside the block.

Top module: `acc_arith_unit`

## Requirements
- R1: With `op` = 2'b00 (add) and `dec_mode` = 0, `result` = `opnd_a` + `opnd_b` + `carry_in`, truncated to the active width. `c_out` is the carry out of the active width.
- R2: With `op` = 2'b01 (subtract) and `dec_mode` = 0, `result` = `opnd_a` − `opnd_b` − (1 − `carry_in`), truncated to the active width. `c_out` is 1 when no borrow was needed and 0 when one was.
- R3: For add and subtract, `v_out` is set when the binary sum or difference overflows as a two's-complement value at the active width. The value used is the one before any decimal correction, so this also holds in decimal mode.
- R4: `n_out` equals the most significant bit of `result` at the active width, which is bit 7 or bit 15. `z_out` is 1 exactly when `result` is zero at the active width.
- R5: With `op` = 2'b00 and `dec_mode` = 1, valid packed-decimal operands give the packed-decimal value of (A + B + `carry_in`) mod 10^k, where k is 2 in byte mode and 4 in word mode. `c_out` is 1 when that sum reaches 10^k.
- R6: With `op` = 2'b01 and `dec_mode` = 1, valid packed-decimal operands give the packed-decimal value of (A − B − (1 − `carry_in`)) mod 10^k. `c_out` is 1 when the difference is not negative.
- R7: With `op` = 2'b10 (increment) the result is `opnd_a` + 1, and with `op` = 2'b11 (decrement) it is `opnd_a` − 1, both wrapping at the active width. `carry_in`, `dec_mode` and `opnd_b` have no effect on these results.
- R8: Add and subtract assert all four write enables. Increment and decrement assert only `n_we` and `z_we`. For them `c_out` passes `carry_in` through unchanged and `v_out` is 0.
- R9: `byte_mode` = 1 selects 8-bit operation: `result[15:8]` is 0, and the upper bytes of both operands have no effect. `byte_mode` = 0 selects 16-bit operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | Accumulator operand |
| opnd_b | input | 16 | Data operand |
| carry_in | input | 1 | Incoming carry flag |
| dec_mode | input | 1 | 1 = packed-decimal add/subtract |
| byte_mode | input | 1 | 1 = 8-bit, 0 = 16-bit |
| op | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| result | output | 16 | Result, upper byte zero in 8-bit mode |
| n_out | output | 1 | Negative flag value |
| v_out | output | 1 | Overflow flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| n_we | output | 1 | Negative flag write enable |
| v_we | output | 1 | Overflow flag write enable |
| z_we | output | 1 | Zero flag write enable |
| c_we | output | 1 | Carry flag write enable |

## Verification
The block holds no state, so a wrong internal value shows up at the ports in the same evaluation that produces it. A wrong digit carry in the decimal chain shows as a digit off by six or by one in the next digit, or as a wrong `c_out`. A wrong tap for the byte/word carry shows only where the low byte carries out, so the sweeps cover every low-byte value in each mode. A bad operation steering shows as wrong write enables, or as increment and decrement picking up `carry_in` or decimal correction.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

    typedef enum logic [1:0] {
        OP_ADC = 2'b00,
        OP_SBC = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } acc_op_e;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } acc_flags_t;

endpackage

// File: rtl/acc_bin_adder.sv
// Two-stage binary adder: low half, then high half. The carry at the active width is taken from the low half in byte mode.
module acc_bin_adder #(
    parameter int HALF_W = 8,
    parameter int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    input  logic              cin,
    input  logic              byte_mode,
    output logic [FULL_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [HALF_W:0] lo;
    logic [HALF_W:0] hi;
    logic            msb_a, msb_b, msb_s;

    always_comb begin
        lo  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        hi  = {1'b0, a[FULL_W-1:HALF_W]} + {1'b0, b[FULL_W-1:HALF_W]}
            + {{HALF_W{1'b0}}, lo[HALF_W]};
        sum = {hi[HALF_W-1:0], lo[HALF_W-1:0]};
        if (byte_mode) begin
            cout  = lo[HALF_W];
            msb_a = a[HALF_W-1];
            msb_b = b[HALF_W-1];
            msb_s = lo[HALF_W-1];
        end else begin
            cout  = hi[HALF_W];
            msb_a = a[FULL_W-1];
            msb_b = b[FULL_W-1];
            msb_s = hi[HALF_W-1];
        end
        ovf = (msb_a == msb_b) && (msb_s != msb_a);
    end
endmodule

// File: rtl/acc_bcd_digit.sv
// One packed-decimal digit. On add, cin/cout is the decimal carry. On subtract, cin/cout means "no borrow".
module acc_bcd_digit
    import acc_arith_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [NIB_W-1:0] d,
    output logic             cout
);
    logic [NIB_W-1:0] bx;
    logic [NIB_W:0]   t;

    always_comb begin
        bx = sub ? ~b : b;
        t  = {1'b0, a} + {1'b0, bx} + {{NIB_W{1'b0}}, cin};
        if (sub) begin
            cout = t[NIB_W];
            d    = t[NIB_W] ? t[NIB_W-1:0] : t[NIB_W-1:0] - 4'd6;
        end else if (t > 5'd9) begin
            cout = 1'b1;
            d    = t[NIB_W-1:0] + 4'd6;
        end else begin
            cout = 1'b0;
            d    = t[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/acc_bcd_chain.sv
// Ripple of decimal digits across the full width. In byte mode the carry is tapped at the half-way digit.
module acc_bcd_chain
    import acc_arith_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    input  logic              byte_mode,
    output logic [FULL_W-1:0] sum,
    output logic              cout
);
    localparam int N_DIG = FULL_W / NIB_W;
    localparam int HALF_DIG = N_DIG / 2;

    logic [N_DIG:0] carry;
    assign carry[0] = cin;

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        acc_bcd_digit u_dig (
            .a    (a[g*NIB_W +: NIB_W]),
            .b    (b[g*NIB_W +: NIB_W]),
            .cin  (carry[g]),
            .sub  (sub),
            .d    (sum[g*NIB_W +: NIB_W]),
            .cout (carry[g+1])
        );
    end

    assign cout = byte_mode ? carry[HALF_DIG] : carry[N_DIG];
endmodule

// File: rtl/acc_flag_gen.sv
module acc_flag_gen
    import acc_arith_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] res,
    input  logic              byte_mode,
    input  acc_op_e           op,
    input  logic              dec_eff,
    input  logic              bin_cout,
    input  logic              bin_ovf,
    input  logic              bcd_cout,
    input  logic              carry_in,
    output acc_flags_t        flags,
    output acc_flags_t        wen
);
    always_comb begin
        flags.n = byte_mode ? res[HALF_W-1] : res[FULL_W-1];
        flags.z = (res == '0);
        unique case (op)
            OP_ADC, OP_SBC: begin
                flags.c = dec_eff ? bcd_cout : bin_cout;
                flags.v = bin_ovf;
                wen     = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_INC, OP_DEC: begin
                flags.c = carry_in;
                flags.v = 1'b0;
                wen     = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            end
        endcase
    end
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
    import acc_arith_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] opnd_a,
    input  logic [FULL_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic              dec_mode,
    input  logic              byte_mode,
    input  logic [1:0]        op,
    output logic [FULL_W-1:0] result,
    output logic              n_out,
    output logic              v_out,
    output logic              z_out,
    output logic              c_out,
    output logic              n_we,
    output logic              v_we,
    output logic              z_we,
    output logic              c_we
);
    acc_op_e          op_e;
    logic             is_step;
    logic             sub_eff;
    logic             cin_eff;
    logic             dec_eff;
    logic [FULL_W-1:0] b_eff;
    logic [FULL_W-1:0] b_bin;
    logic [FULL_W-1:0] bin_sum;
    logic [FULL_W-1:0] bcd_sum;
    logic [FULL_W-1:0] raw_sum;
    logic             bin_cout, bin_ovf, bcd_cout;
    acc_flags_t       flags, wen;

    // Increment and decrement reuse the add path with a constant operand of one.
    always_comb begin
        op_e    = acc_op_e'(op);
        is_step = (op_e == OP_INC) || (op_e == OP_DEC);
        sub_eff = (op_e == OP_SBC) || (op_e == OP_DEC);
        cin_eff = is_step ? sub_eff : carry_in;
        dec_eff = dec_mode && !is_step;
        b_eff   = is_step ? {{(FULL_W-1){1'b0}}, 1'b1} : opnd_b;
        b_bin   = sub_eff ? ~b_eff : b_eff;
    end

    acc_bin_adder #(.HALF_W(HALF_W), .FULL_W(FULL_W)) u_bin (
        .a         (opnd_a),
        .b         (b_bin),
        .cin       (cin_eff),
        .byte_mode (byte_mode),
        .sum       (bin_sum),
        .cout      (bin_cout),
        .ovf       (bin_ovf)
    );

    acc_bcd_chain #(.HALF_W(HALF_W), .FULL_W(FULL_W)) u_bcd (
        .a         (opnd_a),
        .b         (b_eff),
        .cin       (cin_eff),
        .sub       (sub_eff),
        .byte_mode (byte_mode),
        .sum       (bcd_sum),
        .cout      (bcd_cout)
    );

    always_comb begin
        raw_sum = dec_eff ? bcd_sum : bin_sum;
        result  = byte_mode ? {{HALF_W{1'b0}}, raw_sum[HALF_W-1:0]} : raw_sum;
    end

    acc_flag_gen #(.HALF_W(HALF_W), .FULL_W(FULL_W)) u_flags (
        .res       (result),
        .byte_mode (byte_mode),
        .op        (op_e),
        .dec_eff   (dec_eff),
        .bin_cout  (bin_cout),
        .bin_ovf   (bin_ovf),
        .bcd_cout  (bcd_cout),
        .carry_in  (carry_in),
        .flags     (flags),
        .wen       (wen)
    );

    assign n_out = flags.n;
    assign v_out = flags.v;
    assign z_out = flags.z;
    assign c_out = flags.c;
    assign n_we  = wen.n;
    assign v_we  = wen.v;
    assign z_we  = wen.z;
    assign c_we  = wen.c;
endmodule

// File: rtl/acc_arith_chk.sv
module acc_arith_chk #(
    parameter int HALF_W = 8,
    parameter int FULL_W = 2 * HALF_W
) (
    input logic [FULL_W-1:0] opnd_a,
    input logic [FULL_W-1:0] opnd_b,
    input logic              carry_in,
    input logic              dec_mode,
    input logic              byte_mode,
    input logic [1:0]        op,
    input logic [FULL_W-1:0] result,
    input logic              n_out,
    input logic              v_out,
    input logic              z_out,
    input logic              c_out,
    input logic              n_we,
    input logic              v_we,
    input logic              z_we,
    input logic              c_we
);
    logic [HALF_W:0] add_lo;
    logic [FULL_W:0] add_full;

    always_comb begin
        add_lo   = {1'b0, opnd_a[HALF_W-1:0]} + {1'b0, opnd_b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, carry_in};
        add_full = {1'b0, opnd_a} + {1'b0, opnd_b} + {{FULL_W{1'b0}}, carry_in};
    end

    always_comb begin
        p_bin_add_r1: assert (!(op == 2'b00 && !dec_mode) ||
                              (byte_mode ? ({c_out, result[HALF_W-1:0]} == add_lo)
                                         : ({c_out, result} == add_full)))
            else $error("binary add mismatch");
        p_neg_flag_r4: assert (n_out == (byte_mode ? result[HALF_W-1] : result[FULL_W-1]))
            else $error("negative flag mismatch");
        p_zero_flag_r4: assert (z_out == (result == '0))
            else $error("zero flag mismatch");
        p_step_keep_carry_r8: assert (!op[1] || (c_out == carry_in && !v_out))
            else $error("step op altered carry or overflow");
        p_step_wen_r8: assert (!op[1] || (n_we && z_we && !v_we && !c_we))
            else $error("step op write enables wrong");
        p_arith_wen_r8: assert (op[1] || (n_we && z_we && v_we && c_we))
            else $error("arith op write enables wrong");
        p_upper_zero_r9: assert (!byte_mode || result[FULL_W-1:HALF_W] == '0)
            else $error("upper byte not cleared");
    end
endmodule

bind acc_arith_unit acc_arith_chk #(.HALF_W(HALF_W), .FULL_W(FULL_W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .dec_mode  (dec_mode),
    .byte_mode (byte_mode),
    .op        (op),
    .result    (result),
    .n_out     (n_out),
    .v_out     (v_out),
    .z_out     (z_out),
    .c_out     (c_out),
    .n_we      (n_we),
    .v_we      (v_we),
    .z_we      (z_we),
    .c_we      (c_we)
);

// File: tb/tb_acc_arith_unit.sv
module tb_acc_arith_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        dec_mode = 1'b0;
    logic        byte_mode = 1'b1;
    logic [1:0]  op = 2'b00;
    logic [15:0] result;
    logic        n_out, v_out, z_out, c_out, n_we, v_we, z_we, c_we;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    acc_arith_unit dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .dec_mode(dec_mode), .byte_mode(byte_mode), .op(op),
        .result(result), .n_out(n_out), .v_out(v_out), .z_out(z_out),
        .c_out(c_out), .n_we(n_we), .v_we(v_we), .z_we(z_we), .c_we(c_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d",
                     cycles, WATCHDOG_CYCLES);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic int bcd_to_int(input int v, input int digits);
        int r = 0;
        int w = 1;
        for (int i = 0; i < digits; i++) begin
            r += ((v >> (4*i)) & 15) * w;
            w *= 10;
        end
        return r;
    endfunction

    function automatic int int_to_bcd(input int v, input int digits);
        int r = 0;
        int x = v;
        for (int i = 0; i < digits; i++) begin
            r |= (x % 10) << (4*i);
            x /= 10;
        end
        return r;
    endfunction

    task automatic run(input logic [1:0] o, input int a, input int b, input bit cin,
                       input bit dm, input bit bm, input string tag);
        int w, mask, am, bm_v, res, s, lim, digits, sa, sb, sv;
        bit en, ev, ez, ec;
        logic [23:0] got, exp_v;
        opnd_a = a[15:0]; opnd_b = b[15:0]; carry_in = cin;
        dec_mode = dm; byte_mode = bm; op = o;
        #1;
        w = bm ? 8 : 16;
        mask = (1 << w) - 1;
        am = a & mask;
        bm_v = b & mask;
        digits = w / 4;
        lim = (digits == 2) ? 100 : 10000;
        sa = (am >= (1 << (w-1))) ? am - (1 << w) : am;
        sb = (bm_v >= (1 << (w-1))) ? bm_v - (1 << w) : bm_v;
        ev = 0; ec = cin;
        case (o)
            2'b00: begin
                sv = sa + sb + int'(cin);
                if (dm) begin
                    s = bcd_to_int(am, digits) + bcd_to_int(bm_v, digits) + int'(cin);
                    ec = s >= lim;
                    res = int_to_bcd(s % lim, digits);
                end else begin
                    s = am + bm_v + int'(cin);
                    ec = s > mask;
                    res = s & mask;
                end
                ev = (sv > (1 << (w-1)) - 1) || (sv < -(1 << (w-1)));
            end
            2'b01: begin
                sv = sa - sb - (1 - int'(cin));
                if (dm) begin
                    s = bcd_to_int(am, digits) - bcd_to_int(bm_v, digits) - (1 - int'(cin));
                    ec = s >= 0;
                    res = int_to_bcd((s + lim) % lim, digits);
                end else begin
                    s = am - bm_v - (1 - int'(cin));
                    ec = s >= 0;
                    res = s & mask;
                end
                ev = (sv > (1 << (w-1)) - 1) || (sv < -(1 << (w-1)));
            end
            2'b10: res = (am + 1) & mask;
            default: res = (am - 1) & mask;
        endcase
        en = ((res >> (w-1)) & 1) != 0;
        ez = (res == 0);
        exp_v = {res[15:0], en, ev, ez, ec, 1'b1, ~o[1], 1'b1, ~o[1]};
        got   = {result, n_out, v_out, z_out, c_out, n_we, v_we, z_we, c_we};
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%0b dec=%0b byte=%0b: actual %h expected %h",
                     tag, o, a[15:0], b[15:0], cin, dm, bm, got, exp_v);
        end
        #1;
    endtask

    initial begin
        int corners[6];
        corners = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF};
        #3;
        // Idle state with all inputs zero: result 0, Z set (R4).
        run(2'b00, 0, 0, 0, 0, 1, "R4 idle");

        // 8-bit binary add/subtract, garbage upper bytes (R1 R2 R3 R4 R9).
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
                for (int c = 0; c < 2; c++) begin
                    run(2'b00, a | ((a*37 & 255) << 8), b | ((b*91 & 255) << 8), c[0], 0, 1, "R1/R3/R9");
                    run(2'b01, a | ((b*13 & 255) << 8), b | ((a*59 & 255) << 8), c[0], 0, 1, "R2/R3/R9");
                end

        // 8-bit decimal, every valid digit pair (R5 R6 R3).
        for (int x = 0; x < 100; x++)
            for (int y = 0; y < 100; y++)
                for (int c = 0; c < 2; c++) begin
                    run(2'b00, int_to_bcd(x, 2) | 16'hA500, int_to_bcd(y, 2), c[0], 1, 1, "R5/R3");
                    run(2'b01, int_to_bcd(x, 2), int_to_bcd(y, 2) | 16'h3C00, c[0], 1, 1, "R6/R3");
                end

        // 8-bit increment/decrement, carry and decimal must not matter (R7 R8).
        for (int a = 0; a < 256; a++)
            for (int c = 0; c < 2; c++)
                for (int d = 0; d < 2; d++) begin
                    run(2'b10, a | 16'h5A00, a ^ 16'h0F0F, c[0], d[0], 1, "R7/R8 inc");
                    run(2'b11, a | 16'hC300, a ^ 16'hF0F0, c[0], d[0], 1, "R7/R8 dec");
                end

        // 16-bit binary corners and pseudo-random (R9 R1 R2 R3).
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int c = 0; c < 2; c++) begin
                    run(2'b00, corners[i], corners[j], c[0], 0, 0, "R9/R1 wide");
                    run(2'b01, corners[i], corners[j], c[0], 0, 0, "R9/R2 wide");
                end
        for (int i = 0; i < 4000; i++) begin
            int ra, rb;
            ra = int'(next_rand() & 16'hFFFF);
            rb = int'(next_rand() & 16'hFFFF);
            run(2'b00, ra, rb, ra[3], 0, 0, "R9/R1/R3 wide");
            run(2'b01, ra, rb, rb[5], 0, 0, "R9/R2/R3 wide");
        end

        // 16-bit decimal corners and pseudo-random (R5 R6).
        run(2'b00, 16'h9999, 16'h0001, 0, 1, 0, "R5 wide wrap");
        run(2'b00, 16'h9999, 16'h9999, 1, 1, 0, "R5 wide max");
        run(2'b01, 16'h0000, 16'h0001, 1, 1, 0, "R6 wide borrow");
        run(2'b01, 16'h1000, 16'h0000, 0, 1, 0, "R6 wide chain");
        for (int i = 0; i < 2000; i++) begin
            int ra, rb;
            ra = int_to_bcd(int'(next_rand() % 10000), 4);
            rb = int_to_bcd(int'(next_rand() % 10000), 4);
            run(2'b00, ra, rb, ra[0], 1, 0, "R5/R3 wide");
            run(2'b01, ra, rb, rb[4], 1, 0, "R6/R3 wide");
        end

        // 16-bit increment/decrement corners (R7 R8 R9).
        for (int i = 0; i < 6; i++)
            for (int c = 0; c < 2; c++) begin
                run(2'b10, corners[i], 16'h1234, c[0], c[0], 0, "R7/R8 wide inc");
                run(2'b11, corners[i], 16'h4321, c[0], ~c[0], 0, "R7/R8 wide dec");
            end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule